// File: doc/BRIEF.md
# Command Queue Entry Decoder

This block sits between the command-queue fetch logic and the configuration and translation caches of an I/O address translation unit. Each cycle it may be offered one 128-bit command entry made of four 32-bit words. It reads the opcode from the low byte of the first word and sorts the command into a small set of kinds. It pulls out the stream, substream, VMID, ASID, address, leaf, range and completion-signal operands and places the decoded command in a one-entry output register. That register feeds a valid/ready interface toward the caches. An entry counts as consumed only in the cycle it is taken, and that strobe tells the queue pointer unit to advance its consumer index.

Processing is gated by a command-queue enable bit from the control register. The opcode space has gaps. If the entry holds an opcode outside the defined set, or arrived with a fetch fault, the decoder does not consume it. It records an error code, raises a one-cycle error pulse and stalls. The stall lasts until software rewrites the consumer register, which is signalled on a strobe input. A sync command that asks for an interrupt on completion produces a completion pulse. The pulse comes once the sync itself has been accepted downstream, which, because commands leave in order, means every earlier command has been accepted too.

Top module: `cmdq_decoder`

## Requirements
- R1: After a synchronous reset, `dec_valid`, `ent_take`, `err_pulse`, `halted`, `err_code` and `sync_done` are all low or zero.
- R2: The legal opcodes (word0 bits 7:0) are 0x01–0x07, 0x10–0x13, 0x18, 0x1a, 0x20–0x23, 0x28, 0x2a, 0x30, 0x40, 0x41, 0x44, 0x45 and 0x46. An enabled, non-halted, non-faulted entry with any other opcode, 0x00 included, is not taken. One cycle later `halted` is 1, `err_code` is 1 and `err_pulse` is high for exactly one cycle.
- R3: `dec_op` carries the opcode. `dec_kind` is 0 for 0x01–0x02, 1 for 0x03–0x07, 2 for 0x10–0x30, 3 for 0x40, 4 for 0x41/0x44/0x45 and 5 for 0x46.
- R4: `dec_sid` is all of word1. `dec_vmid` is word1[15:0] and `dec_asid` is word1[31:16]. `dec_ssid` is word0[31:12], `dec_ssv` is word0[11] and `dec_ssec` is word0[10].
- R5: `dec_addr` is {word3, word2[31:12], 12'h000}. `dec_leaf` is word2[0] and `dec_range` is word2[4:0].
- R6: `dec_cs` is word0[13:12] for opcode 0x46 (0 none, 1 interrupt, 2 event) and 0 for every other opcode.
- R7: While `cq_en` is 0, no entry is taken and no error is raised, whatever the entry holds.
- R8: An enabled, non-halted entry with `ent_fault` set is not taken. One cycle later `halted` is 1, `err_code` is 2 and `err_pulse` pulses. The fault takes priority over an illegal opcode.
- R9: `halted` and `err_code` hold while `cons_wr` is low. A `cons_wr` pulse while halted clears both one cycle later, and entries are taken again from that cycle on.
- R10: A legal entry is taken (`ent_take`) in the cycle it is offered when the output register is empty or being drained. Decoded commands leave in order, with none lost or duplicated, and are held stable while `dec_ready` is low.
- R11: `sync_done` pulses for one cycle, in the cycle after a 0x46 command with `dec_cs` = 1 is accepted downstream. It does not pulse for any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cq_en | input | 1 | Command-queue enable from the control register |
| ent_valid | input | 1 | A command entry is offered |
| ent_data | input | 128 | Entry; word0 in bits 31:0 through word3 in bits 127:96 |
| ent_fault | input | 1 | The offered entry's fetch aborted |
| ent_take | output | 1 | Entry consumed this cycle; advance the consumer index |
| cons_wr | input | 1 | Software rewrote the consumer register; releases a stall |
| dec_valid | output | 1 | Decoded command available |
| dec_ready | input | 1 | Downstream accepts the decoded command |
| dec_op | output | 8 | Opcode |
| dec_kind | output | 3 | Command kind |
| dec_sid | output | 32 | Stream ID |
| dec_ssid | output | 20 | Substream ID |
| dec_ssv | output | 1 | Substream ID valid |
| dec_ssec | output | 1 | Security flag |
| dec_vmid | output | 16 | VMID |
| dec_asid | output | 16 | ASID |
| dec_addr | output | 64 | Address operand |
| dec_leaf | output | 1 | Leaf flag |
| dec_range | output | 5 | Stream-range field |
| dec_cs | output | 2 | Sync completion-signal request |
| sync_done | output | 1 | Interrupt-requesting sync completed downstream |
| err_pulse | output | 1 | One-cycle pulse when an error is recorded |
| err_code | output | 7 | Recorded error code: 0 none, 1 illegal, 2 abort |
| halted | output | 1 | Consumption stalled on an error |

## Verification
The bench builds the decoder with its default parameters: a 7-bit error field, illegal code 1 and abort code 2. That makes both error paths and their priority observable on `err_code`. The 128-bit entry is fixed by the package, so random words reach every operand bit position, and random bytes reach both the gaps in the opcode map and its edges. Random downstream back-pressure combined with sync commands of every completion value exercises the hold, ordering and completion-pulse timing.

// File: rtl/cmdq_dec_pkg.sv
package cmdq_dec_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int ENTRY_W   = WORD_W * NUM_WORDS;
  localparam int OP_W      = 8;
  localparam int SSID_W    = 20;
  localparam int ID16_W    = 16;
  localparam int ADDR_W    = 2 * WORD_W;
  localparam int PAGE_SH   = 12;
  localparam int RANGE_W   = 5;
  localparam int CS_W      = 2;
  localparam int KIND_W    = 3;

  typedef enum logic [KIND_W-1:0] {
    K_PREFETCH = 3'd0,
    K_CFGI     = 3'd1,
    K_TLBI     = 3'd2,
    K_ATC      = 3'd3,
    K_STALL    = 3'd4,
    K_SYNC     = 3'd5,
    K_NONE     = 3'd7
  } kind_e;

  localparam logic [OP_W-1:0] OP_SYNC = 8'h46;
  localparam logic [CS_W-1:0] CS_IRQ  = 2'd1;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [KIND_W-1:0]  kind;
    logic [WORD_W-1:0]  sid;
    logic [SSID_W-1:0]  ssid;
    logic               ssv;
    logic               ssec;
    logic [ID16_W-1:0]  vmid;
    logic [ID16_W-1:0]  asid;
    logic [ADDR_W-1:0]  addr;
    logic               leaf;
    logic [RANGE_W-1:0] range;
    logic [CS_W-1:0]    cs;
  } dec_t;

  // Sparse opcode map; anything not listed maps to K_NONE (illegal).
  function automatic kind_e classify(input logic [OP_W-1:0] op);
    kind_e k;
    case (op) inside
      [8'h01:8'h02]:                   k = K_PREFETCH;
      [8'h03:8'h07]:                   k = K_CFGI;
      [8'h10:8'h13], 8'h18, 8'h1a,
      [8'h20:8'h23], 8'h28, 8'h2a,
      8'h30:                           k = K_TLBI;
      8'h40:                           k = K_ATC;
      8'h41, 8'h44, 8'h45:             k = K_STALL;
      8'h46:                           k = K_SYNC;
      default:                         k = K_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/cmdq_op_classify.sv
module cmdq_op_classify
  import cmdq_dec_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  output logic              legal,
  output logic [KIND_W-1:0] kind
);
  kind_e k;

  always_comb begin
    k     = classify(op);
    kind  = k;
    legal = (k != K_NONE);
  end
endmodule

// File: rtl/cmdq_field_extract.sv
module cmdq_field_extract
  import cmdq_dec_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic [KIND_W-1:0]  kind,
  output dec_t               fields
);
  logic [WORD_W-1:0] w [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_split
    assign w[i] = entry[i*WORD_W +: WORD_W];
  end

  always_comb begin
    fields.op    = w[0][OP_W-1:0];
    fields.kind  = kind;
    fields.sid   = w[1];
    fields.ssid  = w[0][WORD_W-1 -: SSID_W];
    fields.ssv   = w[0][11];
    fields.ssec  = w[0][10];
    fields.vmid  = w[1][ID16_W-1:0];
    fields.asid  = w[1][WORD_W-1 -: ID16_W];
    fields.addr  = {w[3], w[2][WORD_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    fields.leaf  = w[2][0];
    fields.range = w[2][RANGE_W-1:0];
    fields.cs    = (w[0][OP_W-1:0] == OP_SYNC) ? w[0][13:12] : '0;
  end
endmodule

// File: rtl/cmdq_out_slot.sv
module cmdq_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else if (in_ready) full_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end
endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
  import cmdq_dec_pkg::*;
#(
  parameter int              ERR_W    = 7,
  parameter logic [ERR_W-1:0] ILL_CODE = 7'd1,
  parameter logic [ERR_W-1:0] ABT_CODE = 7'd2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cq_en,
  input  logic               ent_valid,
  input  logic [127:0]       ent_data,
  input  logic               ent_fault,
  output logic               ent_take,
  input  logic               cons_wr,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [7:0]         dec_op,
  output logic [2:0]         dec_kind,
  output logic [31:0]        dec_sid,
  output logic [19:0]        dec_ssid,
  output logic               dec_ssv,
  output logic               dec_ssec,
  output logic [15:0]        dec_vmid,
  output logic [15:0]        dec_asid,
  output logic [63:0]        dec_addr,
  output logic               dec_leaf,
  output logic [4:0]         dec_range,
  output logic [1:0]         dec_cs,
  output logic               sync_done,
  output logic               err_pulse,
  output logic [ERR_W-1:0]   err_code,
  output logic               halted
);
  localparam int DEC_W = $bits(dec_t);

  logic              legal;
  logic [KIND_W-1:0] kind;
  dec_t              fields;
  dec_t              head;
  logic              slot_ready;
  logic              live;
  logic              bad;
  logic              halted_q;
  logic [ERR_W-1:0]  code_q;
  logic              errp_q;
  logic              sync_q;

  cmdq_op_classify u_cls (
    .op    (ent_data[OP_W-1:0]),
    .legal (legal),
    .kind  (kind)
  );

  cmdq_field_extract u_ext (
    .entry  (ent_data),
    .kind   (kind),
    .fields (fields)
  );

  assign live     = cq_en && ent_valid && !halted_q;
  assign bad      = live && (ent_fault || !legal);
  assign ent_take = live && !ent_fault && legal && slot_ready;

  cmdq_out_slot #(.W(DEC_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ent_take),
    .in_data   (fields),
    .in_ready  (slot_ready),
    .out_valid (dec_valid),
    .out_data  (head),
    .out_ready (dec_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      code_q   <= '0;
      errp_q   <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      errp_q <= bad;
      if (bad) begin
        halted_q <= 1'b1;
        code_q   <= ent_fault ? ABT_CODE : ILL_CODE;
      end else if (cons_wr) begin
        halted_q <= 1'b0;
        code_q   <= '0;
      end
      sync_q <= dec_valid && dec_ready && (head.op == OP_SYNC) && (head.cs == CS_IRQ);
    end
  end

  assign halted    = halted_q;
  assign err_code  = code_q;
  assign err_pulse = errp_q;
  assign sync_done = sync_q;

  assign dec_op    = head.op;
  assign dec_kind  = head.kind;
  assign dec_sid   = head.sid;
  assign dec_ssid  = head.ssid;
  assign dec_ssv   = head.ssv;
  assign dec_ssec  = head.ssec;
  assign dec_vmid  = head.vmid;
  assign dec_asid  = head.asid;
  assign dec_addr  = head.addr;
  assign dec_leaf  = head.leaf;
  assign dec_range = head.range;
  assign dec_cs    = head.cs;
endmodule

// File: rtl/cmdq_decoder_chk.sv
module cmdq_decoder_chk #(
  parameter int ERR_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cq_en,
  input logic             ent_valid,
  input logic             ent_fault,
  input logic             ent_take,
  input logic             cons_wr,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic [7:0]       dec_op,
  input logic [31:0]      dec_sid,
  input logic [63:0]      dec_addr,
  input logic [1:0]       dec_cs,
  input logic             sync_done,
  input logic             err_pulse,
  input logic [ERR_W-1:0] err_code,
  input logic             halted
);
  // R7
  take_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ent_take |-> (cq_en && ent_valid && !halted));

  // R8
  fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_en && ent_valid && !halted && ent_fault) |=> (halted && err_pulse && err_code == 2));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !cons_wr) |=> (halted && $stable(err_code)));

  // R9
  halt_release_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && cons_wr) |=> (!halted && err_code == 0));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_op) && $stable(dec_sid) && $stable(dec_addr)));

  // R11
  sync_done_chk: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> $past(dec_valid && dec_ready && dec_op == 8'h46 && dec_cs == 2'd1));

  // R6
  cs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_op != 8'h46) |-> (dec_cs == 2'd0));

  // R5
  addr_page_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_addr[11:0] == 12'h000));
endmodule

bind cmdq_decoder cmdq_decoder_chk #(.ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cq_en     (cq_en),
  .ent_valid (ent_valid),
  .ent_fault (ent_fault),
  .ent_take  (ent_take),
  .cons_wr   (cons_wr),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .dec_op    (dec_op),
  .dec_sid   (dec_sid),
  .dec_addr  (dec_addr),
  .dec_cs    (dec_cs),
  .sync_done (sync_done),
  .err_pulse (err_pulse),
  .err_code  (err_code),
  .halted    (halted)
);

// File: tb/cmdq_decoder_test.sv
module cmdq_decoder_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         cq_en, ent_valid, ent_fault, cons_wr, dec_ready;
  logic [127:0] ent_data;
  logic         ent_take, dec_valid, dec_ssv, dec_ssec, dec_leaf, sync_done, err_pulse, halted;
  logic [7:0]   dec_op;
  logic [2:0]   dec_kind;
  logic [31:0]  dec_sid;
  logic [19:0]  dec_ssid;
  logic [15:0]  dec_vmid, dec_asid;
  logic [63:0]  dec_addr;
  logic [4:0]   dec_range;
  logic [1:0]   dec_cs;
  logic [6:0]   err_code;

  always #2 clk = ~clk;

  cmdq_decoder uut (.*);

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  kind;
    logic [31:0] sid;
    logic [19:0] ssid;
    logic        ssv;
    logic        ssec;
    logic [15:0] vmid;
    logic [15:0] asid;
    logic [63:0] addr;
    logic        leaf;
    logic [4:0]  range;
    logic [1:0]  cs;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     failures = 0;
  bit     m_halt = 0, m_errp = 0, m_sync = 0;
  logic [6:0] m_code = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_op(input logic [7:0] op);
    return op inside {[8'h01:8'h07], [8'h10:8'h13], 8'h18, 8'h1a, [8'h20:8'h23],
                      8'h28, 8'h2a, 8'h30, 8'h40, 8'h41, 8'h44, 8'h45, 8'h46};
  endfunction

  function automatic logic [2:0] kind_of(input logic [7:0] op);
    if (op <= 8'h02) return 3'd0;
    if (op <= 8'h07) return 3'd1;
    if (op <= 8'h30) return 3'd2;
    if (op == 8'h40) return 3'd3;
    if (op == 8'h46) return 3'd5;
    return 3'd4;
  endfunction

  function automatic exp_t expect_of(input logic [127:0] e);
    exp_t x;
    logic [31:0] w0 = e[31:0], w1 = e[63:32], w2 = e[95:64], w3 = e[127:96];
    x.op = w0[7:0];        x.kind = kind_of(w0[7:0]);
    x.sid = w1;            x.vmid = w1[15:0];  x.asid = w1[31:16];
    x.ssid = w0[31:12];    x.ssv = w0[11];     x.ssec = w0[10];
    x.addr = {w3, w2[31:12], 12'h000};
    x.leaf = w2[0];        x.range = w2[4:0];
    x.cs = (w0[7:0] == 8'h46) ? w0[13:12] : 2'd0;
    return x;
  endfunction

  // Called just after a negedge once inputs are set; ends at the posedge.
  task automatic eval();
    bit   exp_take, bad, hs, sync_nx;
    exp_t h;
    string treq;
    #1;
    chk(halted == m_halt, "R9", "halted", halted, m_halt);
    chk(err_code === m_code, "R9", "err_code", err_code, m_code);
    chk(err_pulse == m_errp, "R2", "err_pulse", err_pulse, m_errp);
    chk(sync_done == m_sync, "R11", "sync_done", sync_done, m_sync);
    chk(dec_valid == (q.size() != 0), "R10", "dec_valid", dec_valid, q.size() != 0);
    exp_take = cq_en && ent_valid && !m_halt && !ent_fault && legal_op(ent_data[7:0])
               && (q.size() == 0 || dec_ready);
    treq = !cq_en ? "R7" : ent_fault ? "R8" : !legal_op(ent_data[7:0]) ? "R2" : "R10";
    chk(ent_take == exp_take, treq, "ent_take", ent_take, exp_take);
    bad = cq_en && ent_valid && !m_halt && (ent_fault || !legal_op(ent_data[7:0]));
    hs = dec_valid && dec_ready && q.size() != 0;
    sync_nx = 0;
    if (hs) begin
      h = q.pop_front();
      chk({dec_op, dec_kind} === {h.op, h.kind}, "R3", "op/kind", {dec_op, dec_kind}, {h.op, h.kind});
      chk({dec_sid, dec_ssid, dec_ssv, dec_ssec, dec_vmid, dec_asid} ===
          {h.sid, h.ssid, h.ssv, h.ssec, h.vmid, h.asid}, "R4", "ids", dec_sid, h.sid);
      chk({dec_addr, dec_leaf, dec_range} === {h.addr, h.leaf, h.range}, "R5", "addr", dec_addr, h.addr);
      chk(dec_cs === h.cs, "R6", "cs", dec_cs, h.cs);
      sync_nx = (h.op == 8'h46) && (h.cs == 2'd1);
    end
    if (exp_take) q.push_back(expect_of(ent_data));
    @(posedge clk);
    m_errp = bad;
    m_sync = sync_nx;
    if (bad) begin
      m_halt = 1;
      m_code = ent_fault ? 7'd2 : 7'd1;
    end else if (cons_wr) begin
      m_halt = 0;
      m_code = '0;
    end
  endtask

  task automatic drive(input bit en, input bit v, input logic [127:0] d,
                       input bit f, input bit cw, input bit rdy);
    @(negedge clk);
    cq_en = en; ent_valid = v; ent_data = d; ent_fault = f; cons_wr = cw; dec_ready = rdy;
    eval();
  endtask

  function automatic logic [127:0] mk(input logic [7:0] op, input logic [1:0] cs);
    logic [127:0] e = {$urandom, $urandom, $urandom, $urandom};
    e[7:0] = op;
    e[13:12] = cs;
    return e;
  endfunction

  function automatic logic [7:0] rand_legal();
    logic [7:0] op;
    do op = 8'($urandom); while (!legal_op(op));
    return op;
  endfunction

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c0d_e5ed));
    rst = 1; cq_en = 0; ent_valid = 0; ent_data = '0; ent_fault = 0; cons_wr = 0; dec_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk({dec_valid, ent_take, err_pulse, halted, sync_done} == 5'b0, "R1", "outputs",
        {dec_valid, ent_take, err_pulse, halted, sync_done}, 0);
    chk(err_code == 0, "R1", "err_code", err_code, 0);

    // R7: illegal opcode with enable low does nothing
    drive(0, 1, mk(8'h00, 0), 0, 0, 1);
    drive(0, 1, mk(8'h46, 1), 0, 0, 1);
    // R2: opcode 0 halts with code 1, then cons_wr releases (R9)
    drive(1, 1, mk(8'h00, 0), 0, 0, 1);
    drive(1, 1, mk(8'h01, 0), 0, 0, 1);
    drive(1, 1, mk(8'h01, 0), 0, 0, 1);
    drive(1, 0, '0, 0, 1, 1);
    // R2 edges of the map: 0x08, 0x47, 0xff
    drive(1, 1, mk(8'h47, 0), 0, 0, 1);
    drive(1, 0, '0, 0, 1, 1);
    drive(1, 1, mk(8'h08, 0), 0, 0, 1);
    drive(1, 0, '0, 0, 1, 1);
    drive(1, 1, mk(8'hff, 0), 0, 0, 1);
    drive(1, 0, '0, 0, 1, 1);
    // R8: fault wins over illegal opcode
    drive(1, 1, mk(8'h00, 0), 1, 0, 1);
    drive(1, 0, '0, 0, 1, 1);
    // R11: sync cs=1 under back-pressure, then cs=2 and cs=0
    drive(1, 1, mk(8'h46, 1), 0, 0, 0);
    drive(1, 1, mk(8'h10, 0), 0, 0, 0);
    drive(1, 0, '0, 0, 0, 0);
    drive(1, 0, '0, 0, 0, 1);
    drive(1, 1, mk(8'h46, 2), 0, 0, 1);
    drive(1, 1, mk(8'h46, 0), 0, 0, 1);
    drive(1, 1, mk(8'h46, 1), 0, 0, 1);
    drive(1, 0, '0, 0, 0, 1);
    drive(1, 0, '0, 0, 0, 1);
    // R3 R4 R5: every legal opcode once
    for (int op = 0; op < 256; op++)
      if (legal_op(8'(op))) drive(1, 1, mk(8'(op), 2'($urandom)), 0, 0, 1);

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] op;
      op = ($urandom % 10 == 0) ? 8'($urandom) : rand_legal();
      drive($urandom % 10 != 0, $urandom % 5 != 0, mk(op, 2'($urandom)),
            $urandom % 40 == 0, m_halt ? ($urandom % 5 == 0) : ($urandom % 50 == 0),
            $urandom % 10 < 7);
    end
    drive(1, 0, '0, 0, 1, 1);
    drive(1, 0, '0, 0, 0, 1);
    drive(1, 0, '0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule